// File: doc/BRIEF.md
# Audio Time-Shift Buffer Controller

This block lets a listener pause, rewind and replay a live audio stream. Every incoming 12-bit sample is written into a circular sample memory, whatever the playback side is doing. A separate read position plays samples back, one per incoming sample period. That read position may trail the write position, so the listener hears delayed audio.

The read position is kept as a lag, which is the number of stored samples not yet played. Decoded command pulses change it:

- pause/play toggle
- skip back by a fixed span
- reverse start and reverse stop
- jump to live
- jump to the oldest retained sample

The lag is clamped so that it never points before the oldest retained sample or past the newest one. Pausing does not stop recording. If the history overflows while paused, the held read position is pushed forward onto the oldest sample that remains.

The memory itself is outside the block. It is reached through a single synchronous port with a one-cycle read latency. Output samples appear with a valid strobe. Two status flags show live and paused playback.

Top module: `timeshift_buffer`

## Requirements
- R1: Each sample strobe writes the sample to the memory at the write address, which then advances by one and wraps modulo 2^ADDR_W.
- R2: In play mode each sample strobe yields exactly one playback sample with a valid pulse, and while live that sample is the one just written.
- R3: A pause toggle stops playback output while recording continues. The next toggle resumes with the first sample not yet played.
- R4: When writes overrun a held read position, the next sample played is the oldest one retained, which is index n - 2^ADDR_W after n writes.
- R5: Skip back moves the read position SKIP_LEN samples earlier, clamped to the oldest retained sample (the first sample written, before the memory fills).
- R6: While reverse is active, each sample period moves the read position REV_STEP samples earlier (clamped to the oldest) and plays that sample. After reverse stops, forward play resumes from the last sample played in reverse.
- R7: Jump to live makes the next played sample the next one written.
- R8: Jump to oldest makes the next played sample the oldest retained sample.
- R9: liveFlag is 1 exactly when the lag is at most one sample. pauseFlag is 1 exactly while playback is paused.
- R10: A write has priority over a read in the same cycle. A pending read waits, so two strobes on consecutive cycles produce one playback sample, taken from the first of the two.
- R11: After reset nothing is stored, liveFlag is 1, pauseFlag is 0 and playValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| smpValid | input | 1 | Incoming sample strobe |
| smpData | input | DATA_W | Incoming sample |
| cmdPauseToggle | input | 1 | Pulse: toggle pause/play |
| cmdSkipBack | input | 1 | Pulse: skip back SKIP_LEN samples |
| cmdRevStart | input | 1 | Pulse: enter reverse play |
| cmdRevStop | input | 1 | Pulse: leave reverse play (wins over start) |
| cmdJumpLive | input | 1 | Pulse: snap to newest (highest seek priority) |
| cmdJumpOldest | input | 1 | Pulse: snap to oldest retained sample |
| ramWe | output | 1 | Memory write enable |
| ramRe | output | 1 | Memory read enable |
| ramAddr | output | ADDR_W | Memory address, shared by write and read |
| ramWdata | output | DATA_W | Memory write data |
| ramRdata | input | DATA_W | Memory read data, one cycle after ramRe |
| playValid | output | 1 | Playback sample valid |
| playData | output | DATA_W | Playback sample |
| liveFlag | output | 1 | Lag is at most one sample |
| pauseFlag | output | 1 | Playback paused |

## Verification
The bench drives the lag into its clamps in several ways:

- A skip issued before the memory has filled must stop on sample zero. A design that wraps around would replay stale memory contents.
- Twenty writes while paused into a sixteen-entry memory must drag the read position forward. A design without this push resumes on overwritten data and plays samples out of order.
- Reverse is held until it pins at the oldest sample, then released. This exposes a wrong step size, a missing clamp, or a lost replay point.
- Back-to-back strobes test the write-over-read priority. A design that reads in the write cycle drives a clashing address or emits an extra sample.

// File: rtl/tshift_pkg.sv
package tshift_pkg;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic doWrite;    // store incoming sample
    logic rdFwd;      // forward playback read
    logic rdRev;      // reverse playback read
    logic seekLive;   // lag := 0
    logic seekOldest; // lag := fill
    logic seekSkip;   // lag += skip span, clamped
  } tsStrobes_t;

endpackage

// File: rtl/tshift_seq.sv
module tshift_seq
  import tshift_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       smpValid,
  input  logic       cmdPauseToggle,
  input  logic       cmdSkipBack,
  input  logic       cmdRevStart,
  input  logic       cmdRevStop,
  input  logic       cmdJumpLive,
  input  logic       cmdJumpOldest,
  input  logic       hasAhead,
  input  logic       hasData,
  output tsStrobes_t strb,
  output logic       paused
);

  logic revOn;
  logic rdPending;
  logic seekAny;
  logic readSlot;

  assign seekAny = cmdJumpLive | cmdJumpOldest | cmdSkipBack;

  // a read may only use a cycle free of writes and seeks
  assign readSlot = rdPending & ~paused & ~smpValid & ~seekAny;

  always_comb begin
    strb            = '0;
    strb.doWrite    = smpValid;
    strb.seekLive   = cmdJumpLive;
    strb.seekOldest = cmdJumpOldest & ~cmdJumpLive;
    strb.seekSkip   = cmdSkipBack & ~cmdJumpLive & ~cmdJumpOldest;
    strb.rdFwd      = readSlot & ~revOn & hasAhead;
    strb.rdRev      = readSlot & revOn & hasData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paused    <= 1'b0;
      revOn     <= 1'b0;
      rdPending <= 1'b0;
    end else begin
      paused <= paused ^ cmdPauseToggle;
      if (cmdRevStop)       revOn <= 1'b0;
      else if (cmdRevStart) revOn <= 1'b1;
      if (smpValid && !paused)     rdPending <= 1'b1;
      else if (readSlot || paused) rdPending <= 1'b0;
    end
  end

  AST_PAUSE_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    cmdPauseToggle |=> (paused != $past(paused))); // R9

  AST_REV_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    cmdRevStop |=> !(strb.rdRev)); // R6

endmodule

// File: rtl/tshift_path.sv
module tshift_path
  import tshift_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int SKIP_LEN = 10,
  parameter int REV_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tsStrobes_t        strb,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              hasAhead,
  output logic              hasData,
  output logic              isLive
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CNT_W    = ADDR_W + 1;
  localparam int SUM_W    = CNT_W + 1;
  localparam int SKIP_EFF = (SKIP_LEN > DEPTH) ? DEPTH : SKIP_LEN;
  localparam int REV_EFF  = (REV_STEP > DEPTH) ? DEPTH : REV_STEP;
  localparam logic [SUM_W-1:0] SKIP_V  = SUM_W'(SKIP_EFF);
  localparam logic [SUM_W-1:0] REV_V   = SUM_W'(REV_EFF);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fill;  // samples retained, saturates at DEPTH
  logic [CNT_W-1:0] lag;   // unplayed samples; next read = wrPtr - lag

  logic [SUM_W-1:0] fillN, lagW, lagInc, lagSkip, lagRev, lagN;

  always_comb begin
    fillN = {1'b0, fill};
    if (strb.doWrite && fill != DEPTH_C) fillN = {1'b0, fill} + SUM_W'(1);

    // a write ages every stored sample; clamp keeps lag on the oldest
    lagInc = {1'b0, lag} + SUM_W'(1);
    lagW   = {1'b0, lag};
    if (strb.doWrite) lagW = (lagInc > fillN) ? fillN : lagInc;

    lagSkip = lagW + SKIP_V;
    if (lagSkip > fillN) lagSkip = fillN;

    lagRev = {1'b0, lag} + REV_V;
    if (lagRev > {1'b0, fill}) lagRev = {1'b0, fill};

    lagN = lagW;
    if (strb.seekLive)        lagN = '0;
    else if (strb.seekOldest) lagN = fillN;
    else if (strb.seekSkip)   lagN = lagSkip;
    else if (strb.rdFwd)      lagN = {1'b0, lag} - SUM_W'(1);
    else if (strb.rdRev)      lagN = lagRev;
  end

  assign rdAddr   = strb.rdRev ? (wrPtr - lagRev[ADDR_W-1:0])
                               : (wrPtr - lag[ADDR_W-1:0]);
  assign hasAhead = (lag != '0);
  assign hasData  = (fill != '0);
  assign isLive   = (lag <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      fill  <= '0;
      lag   <= '0;
    end else begin
      if (strb.doWrite) wrPtr <= wrPtr + ADDR_W'(1);
      fill <= fillN[CNT_W-1:0];
      lag  <= lagN[CNT_W-1:0];
    end
  end

  AST_LAG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lag <= fill); // R4

  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |=> (wrPtr == $past(wrPtr) + ADDR_W'(1))); // R1

  AST_LIVE_SNAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.seekLive |=> isLive); // R7

  AST_OLDEST_SNAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.seekOldest && !strb.doWrite) |=> (lag == fill)); // R8

endmodule

// File: rtl/timeshift_buffer.sv
module timeshift_buffer
  import tshift_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 6,
  parameter int SKIP_LEN = 10,
  parameter int REV_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smpValid,
  input  logic [DATA_W-1:0] smpData,
  input  logic              cmdPauseToggle,
  input  logic              cmdSkipBack,
  input  logic              cmdRevStart,
  input  logic              cmdRevStop,
  input  logic              cmdJumpLive,
  input  logic              cmdJumpOldest,
  output logic              ramWe,
  output logic              ramRe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              playValid,
  output logic [DATA_W-1:0] playData,
  output logic              liveFlag,
  output logic              pauseFlag
);

  tsStrobes_t        strb;
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdAddr;
  logic              hasAhead;
  logic              hasData;
  logic              isLive;
  logic              paused;

  tshift_seq u_seq (
    .clk            (clk),
    .rstN           (rstN),
    .smpValid       (smpValid),
    .cmdPauseToggle (cmdPauseToggle),
    .cmdSkipBack    (cmdSkipBack),
    .cmdRevStart    (cmdRevStart),
    .cmdRevStop     (cmdRevStop),
    .cmdJumpLive    (cmdJumpLive),
    .cmdJumpOldest  (cmdJumpOldest),
    .hasAhead       (hasAhead),
    .hasData        (hasData),
    .strb           (strb),
    .paused         (paused)
  );

  tshift_path #(
    .ADDR_W   (ADDR_W),
    .SKIP_LEN (SKIP_LEN),
    .REV_STEP (REV_STEP)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrPtr    (wrPtr),
    .rdAddr   (rdAddr),
    .hasAhead (hasAhead),
    .hasData  (hasData),
    .isLive   (isLive)
  );

  assign ramWe     = strb.doWrite;
  assign ramRe     = strb.rdFwd | strb.rdRev;
  assign ramAddr   = ramWe ? wrPtr : rdAddr;
  assign ramWdata  = smpData;
  assign playData  = ramRdata;
  assign liveFlag  = isLive;
  assign pauseFlag = paused;

  // memory returns data one cycle after the read request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) playValid <= 1'b0;
    else       playValid <= ramRe;
  end

  AST_WR_OVER_RD: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> !ramRe); // R10

  AST_PAUSED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (pauseFlag && $past(pauseFlag)) |-> !playValid); // R3

endmodule

// File: tb/sim_timeshift_buffer.sv
module sim_timeshift_buffer;

  localparam int CLK_P  = 10;
  localparam int DW     = 12;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;
  localparam int SKIP   = 5;
  localparam int REV    = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          smpValid = 1'b0;
  logic [DW-1:0] smpData = '0;
  logic          cPause = 1'b0, cSkip = 1'b0, cRevS = 1'b0, cRevE = 1'b0;
  logic          cLive = 1'b0, cOld = 1'b0;
  logic          ramWe, ramRe, playValid, liveFlag, pauseFlag;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWdata, playData;
  logic [DW-1:0] ramRdata = '0;
  logic [DW-1:0] mem [DEPTH];

  int checks = 0;
  int errors = 0;
  int n = 0;      // samples written (model)
  int r = 0;      // next index to play (model)
  bit mPaused = 0;
  bit mRev = 0;
  int    expQ[$];
  string tagQ[$];

  always #(CLK_P/2) clk = ~clk;

  timeshift_buffer #(.DATA_W(DW), .ADDR_W(AW), .SKIP_LEN(SKIP), .REV_STEP(REV)) u0 (
    .clk(clk), .rstN(rstN), .smpValid(smpValid), .smpData(smpData),
    .cmdPauseToggle(cPause), .cmdSkipBack(cSkip), .cmdRevStart(cRevS),
    .cmdRevStop(cRevE), .cmdJumpLive(cLive), .cmdJumpOldest(cOld),
    .ramWe(ramWe), .ramRe(ramRe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .ramRdata(ramRdata), .playValid(playValid), .playData(playData),
    .liveFlag(liveFlag), .pauseFlag(pauseFlag)
  );

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
    if (ramRe) ramRdata <= mem[ramAddr];
  end

  function automatic int smpVal(int i);
    return (i * 37 + 5) & 'hFFF;
  endfunction

  function automatic int oldest();
    return (n > DEPTH) ? n - DEPTH : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectPlay(int idx, string tag);
    expQ.push_back(smpVal(idx));
    tagQ.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && playValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected playback actual=%0h expected=none", playData);
      end else begin
        check(tagQ.pop_front(), int'(playData), expQ.pop_front());
      end
    end
  end

  task automatic chkFlags(string tag);
    check({tag, " liveFlag"}, int'(liveFlag), ((n - r) <= 1) ? 1 : 0);
    check({tag, " pauseFlag"}, int'(pauseFlag), int'(mPaused));
  endtask

  task automatic modelPlay(string tag);
    if (mPaused) return;
    if (mRev) begin
      r = (r - REV < oldest()) ? oldest() : r - REV;
      expectPlay(r, tag);
    end else if (r < n) begin
      expectPlay(r, tag);
      r++;
    end
  endtask

  task automatic sendOne(string tag);
    @(negedge clk);
    smpValid = 1'b1;
    smpData  = DW'(smpVal(n));
    @(negedge clk);
    smpValid = 1'b0;
    n++;
    if (r < oldest()) r = oldest();
    modelPlay(tag);
    check("R1 memory write", int'(mem[(n-1) % DEPTH]), smpVal(n-1));
    repeat (3) @(negedge clk);
    chkFlags(tag);
  endtask

  task automatic sendPair(string tag);
    @(negedge clk);
    smpValid = 1'b1;
    smpData  = DW'(smpVal(n));
    @(negedge clk);
    smpData  = DW'(smpVal(n + 1));
    @(negedge clk);
    smpValid = 1'b0;
    n += 2;
    if (r < oldest()) r = oldest();
    modelPlay(tag);
    repeat (3) @(negedge clk);
    chkFlags(tag);
  endtask

  // 0 pause,1 skip,2 revStart,3 revStop,4 live,5 oldest
  task automatic cmd(int which);
    @(negedge clk);
    case (which)
      0: begin cPause = 1'b1; mPaused = !mPaused; end
      1: begin cSkip = 1'b1; r = (r - SKIP < oldest()) ? oldest() : r - SKIP; end
      2: begin cRevS = 1'b1; mRev = 1'b1; end
      3: begin cRevE = 1'b1; mRev = 1'b0; end
      4: begin cLive = 1'b1; r = n; end
      default: begin cOld = 1'b1; r = oldest(); end
    endcase
    @(negedge clk);
    {cPause, cSkip, cRevS, cRevE, cLive, cOld} = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 liveFlag", int'(liveFlag), 1);
    check("R11 pauseFlag", int'(pauseFlag), 0);
    check("R11 playValid", int'(playValid), 0);

    for (int i = 0; i < 6; i++) sendOne("R2 live play");

    cmd(0);
    chkFlags("R9 paused");
    for (int i = 0; i < 3; i++) sendOne("R3 paused");
    cmd(0);
    for (int i = 0; i < 2; i++) sendOne("R3 resume exact");

    cmd(1); cmd(1); cmd(1);
    chkFlags("R5 skip clamp before fill");
    sendOne("R5 skip clamp to first");
    sendOne("R5 after skip");

    cmd(0);
    for (int i = 0; i < 20; i++) sendOne("R4 overrun paused");
    cmd(0);
    sendOne("R4 resume at oldest");
    sendOne("R4 continue");

    cmd(4);
    chkFlags("R7 live");
    sendOne("R7 live next");

    cmd(5);
    chkFlags("R8 oldest");
    sendOne("R8 play oldest");

    cmd(4);
    for (int i = 0; i < 3; i++) sendOne("R2 live again");
    cmd(2);
    for (int i = 0; i < 12; i++) sendOne("R6 reverse");
    cmd(3);
    for (int i = 0; i < 2; i++) sendOne("R6 forward after reverse");

    cmd(4);
    sendOne("R7 live");
    sendPair("R10 back-to-back");
    sendOne("R10 after pair");

    for (int i = 0; i < 8; i++) sendOne("R1 fill");
    cmd(1);
    chkFlags("R5 skip");
    sendOne("R5 skip span");
    sendOne("R5 skip next");

    repeat (10) @(negedge clk);
    check("R2 all expected played", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule